// File: doc/BRIEF.md
# Coprocessor Load Data Alignment Buffer

This block receives load data words from the writeback stage of a host core's load/store path and hands them to the late execute stage of a coprocessor where the matching load instruction waits. Every word passes through a fixed chain of two data-plus-valid registers. The chain carries no tags and has no flow control, so each word reaches the consuming stage in the same cycle as the load instruction that wants it.

The consuming stage raises a load instruction flag together with the number of items the instruction transfers. The block asserts a stall while the instruction is present but the data at the end of the chain, or the core's finish token for that data, is missing. In the cycle both are present the stall drops, a completion pulse fires, and the word is presented to the register-write logic with its element index. A vector load appears as repeated instances of one instruction, each taking one item. An internal counter numbers the items and marks the final one.

The chain is never cleared by anything except reset. Words that are not taken simply shift out, which is what lets flushed or cancelled traffic expire on its own.

Top module: `cpld_align_buf`

## Requirements
- R1: After a synchronous active-low reset, both valid bits of the chain are zero and the item counter is zero. A load instruction arriving with no new data therefore stalls, and the next vector load starts at index 0.
- R2: A word presented with `ld_vld_i` high in cycle N is available at the chain output in cycle N+2, neither earlier nor later.
- R3: The chain shifts every cycle whether or not the stall is asserted. A word that is not taken in its output cycle is lost and is replaced by the word behind it.
- R4: `stall_o` is high exactly when `ins_vld_i` is high and either no valid word is at the chain output or `fin_tok_i` is low.
- R5: In the cycle the stall releases for a present instruction, `done_o` pulses for one cycle and `wr_data_o` carries the word at the chain output. `done_o` and `stall_o` are never both high.
- R6: A valid word at the chain output without `fin_tok_i` does not complete the instruction, which stays stalled. `fin_tok_i` may only be high when a valid word is at the chain output.
- R7: Each completion increments `wr_idx_o` by one, starting from 0. `wr_last_o` pulses with the completion whose index equals `ins_items_i` minus 1, and after it the index returns to 0. An `ins_items_i` of 0 is handled as 1.
- R8: With `ins_vld_i` low, `stall_o` and `done_o` stay low. A valid word must never reach the chain output while no load instruction is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_vld_i | input | 1 | Load word from the core is valid this cycle |
| ld_data_i | input | DATA_W | Load word from the core |
| fin_tok_i | input | 1 | Finish token matching the word at the chain output |
| ins_vld_i | input | 1 | A load instruction occupies the consuming stage |
| ins_items_i | input | CNT_W | Item count of the present (vector) load, 0 treated as 1 |
| stall_o | output | 1 | Freeze the consuming stage and everything behind it |
| done_o | output | 1 | One item completed this cycle |
| wr_data_o | output | DATA_W | Word to write for the completed item |
| wr_idx_o | output | CNT_W | Element index of the item (valid with `done_o`) |
| wr_last_o | output | 1 | Completed item is the last of the instruction |

## Verification
On every cycle the assertions check the per-stage shifting of the valid bits, the stall whenever data is absent, the exclusion between stall and completion, the pairing of the finish token with data, the absence of orphan data when no instruction is present, and the stepping and wrapping of the item index. Only the bench scenarios can show the exact two-cycle arrival time of each word, that the words written out carry the right values in the right order, that a word missed for lack of a token is really lost and replaced by the later one, and that a reset in the middle of traffic discards a word in flight and restarts the index.

// File: rtl/cpld_pkg.sv
// Package: shared constants and width helpers for the coprocessor load
// alignment buffer. Assumes item counts are small positive integers.
package cpld_pkg;

    // Number of register stages between the core writeback and the consumer.
    localparam int unsigned CPLD_ALIGN_DEPTH = 2;

    // Bits needed to hold an item count from 0 up to max_items.
    function automatic int unsigned cnt_bits(input int unsigned max_items);
        return $clog2(max_items + 1);
    endfunction

endpackage

// File: rtl/cpld_stage.sv
// Module: one alignment register holding a data word and its valid bit.
// Assumes no flow control: the stage loads its input on every clock.
// Only the valid bit is reset; the data register is left free-running.
module cpld_stage #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              d_vld,
    input  logic [DATA_W-1:0] d_dat,
    output logic              q_vld,
    output logic [DATA_W-1:0] q_dat
);

    // Valid bit: cleared by reset, otherwise copies the upstream valid.
    always_ff @(posedge clk) begin
        if (!rst_n) q_vld <= 1'b0;
        else        q_vld <= d_vld;
    end

    // Data word: captured every cycle, no reset needed.
    always_ff @(posedge clk) begin
        q_dat <= d_dat;
    end

    // R3
    stage_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (q_vld == $past(d_vld)));

endmodule

// File: rtl/cpld_delay_line.sv
// Module: a chain of DEPTH alignment stages. Assumes the caller chooses
// DEPTH so that words meet their load instruction at the chain output.
module cpld_delay_line #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_dat,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_dat
);

    logic [DEPTH:0]             vld_c;
    logic [DEPTH:0][DATA_W-1:0] dat_c;

    assign vld_c[0] = in_vld;
    assign dat_c[0] = in_dat;

    // Build the stage chain, each stage feeding the next.
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        cpld_stage #(.DATA_W(DATA_W)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .d_vld (vld_c[g]),
            .d_dat (dat_c[g]),
            .q_vld (vld_c[g+1]),
            .q_dat (dat_c[g+1])
        );
    end

    assign out_vld = vld_c[DEPTH];
    assign out_dat = dat_c[DEPTH];

endmodule

// File: rtl/cpld_iter_ctr.sv
// Module: element index counter for repeated instances of a vector load.
// Assumes the item count stays stable while one instruction is present;
// a count of zero is handled as one item.
module cpld_iter_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [CNT_W-1:0] items,
    output logic [CNT_W-1:0] idx_o,
    output logic             last_o
);

    logic [CNT_W:0] nxt;

    // Next index and final-item detection, widened to avoid overflow.
    always_comb begin
        nxt    = {1'b0, idx_o} + 1'b1;
        last_o = (nxt >= {1'b0, items});
    end

    // Index register: advance on each completion, wrap after the last.
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_o <= '0;
        else if (step)   idx_o <= last_o ? '0 : nxt[CNT_W-1:0];
    end

    // R7
    iter_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && last_o |=> (idx_o == '0));

    // R7
    iter_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && !last_o |=> (idx_o == CNT_W'($past(idx_o) + 1'b1)));

    // R7
    iter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(idx_o));

endmodule

// File: rtl/cpld_gate.sv
// Module: stall and completion decision for the consuming stage.
// Assumes the finish token arrives in the cycle its word leaves the chain.
module cpld_gate (
    input  logic ins_vld,
    input  logic data_vld,
    input  logic tok,
    output logic stall,
    output logic fire
);

    // An item completes only when instruction, data and token coincide.
    always_comb begin
        fire  = ins_vld & data_vld & tok;
        stall = ins_vld & ~fire;
    end

endmodule

// File: rtl/cpld_align_buf.sv
// Module: top of the coprocessor load data alignment buffer.
// Delays core load words by a fixed register chain, stalls the consuming
// stage until word and finish token are both present, and numbers the
// items of a vector load. Assumes the load instruction always reaches the
// consuming stage no later than its data and that no flush or cancel can
// strand data: unused words shift out and expire.
module cpld_align_buf #(
    parameter int DATA_W    = 32,
    parameter int MAX_ITEMS = 8,
    parameter int DEPTH     = cpld_pkg::CPLD_ALIGN_DEPTH,
    parameter int CNT_W     = cpld_pkg::cnt_bits(MAX_ITEMS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_vld_i,
    input  logic [DATA_W-1:0] ld_data_i,
    input  logic              fin_tok_i,
    input  logic              ins_vld_i,
    input  logic [CNT_W-1:0]  ins_items_i,
    output logic              stall_o,
    output logic              done_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [CNT_W-1:0]  wr_idx_o,
    output logic              wr_last_o
);

    logic              head_vld;
    logic [DATA_W-1:0] head_dat;
    logic              item_last;

    // Fixed alignment chain between core writeback and the consumer.
    cpld_delay_line #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (ld_vld_i),
        .in_dat  (ld_data_i),
        .out_vld (head_vld),
        .out_dat (head_dat)
    );

    // Stall and completion decision.
    cpld_gate u_gate (
        .ins_vld  (ins_vld_i),
        .data_vld (head_vld),
        .tok      (fin_tok_i),
        .stall    (stall_o),
        .fire     (done_o)
    );

    // Element numbering for vector loads.
    cpld_iter_ctr #(.CNT_W(CNT_W)) u_iter (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (done_o),
        .items  (ins_items_i),
        .idx_o  (wr_idx_o),
        .last_o (item_last)
    );

    // Result presented to register-write logic.
    always_comb begin
        wr_data_o = head_dat;
        wr_last_o = done_o & item_last;
    end

    // R4
    stall_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_vld_i && !head_vld |-> stall_o);

    // R5
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !stall_o);

    // R6
    tok_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin_tok_i |-> head_vld);

    // R8
    orphan_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        head_vld |-> ins_vld_i);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_vld_i |-> (!stall_o && !done_o));

endmodule

// File: tb/cpld_align_buf_tb.sv
// Scoreboard bench: a per-cycle schedule is filled by driver tasks that
// also queue expected completions; the monitor pops on each done_o.
module cpld_align_buf_tb;

    localparam int DW = 32;
    localparam int CW = 4;
    localparam int NC = 80;

    typedef struct packed {
        logic [DW-1:0] d;
        logic [CW-1:0] i;
        logic          l;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_vld_i = 1'b0;
    logic [DW-1:0] ld_data_i = '0;
    logic          fin_tok_i = 1'b0;
    logic          ins_vld_i = 1'b0;
    logic [CW-1:0] ins_items_i = '0;
    logic          stall_o, done_o, wr_last_o;
    logic [DW-1:0] wr_data_o;
    logic [CW-1:0] wr_idx_o;

    bit            s_rst [NC];
    bit            s_ld  [NC];
    logic [DW-1:0] s_dat [NC];
    bit            s_tok [NC];
    bit            s_ins [NC];
    logic [CW-1:0] s_itm [NC];
    string         s_tag [NC];
    exp_t          q[$];

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;

    always #5 clk = ~clk;

    cpld_align_buf #(.DATA_W(DW), .MAX_ITEMS(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .ld_vld_i(ld_vld_i), .ld_data_i(ld_data_i),
        .fin_tok_i(fin_tok_i), .ins_vld_i(ins_vld_i), .ins_items_i(ins_items_i),
        .stall_o(stall_o), .done_o(done_o), .wr_data_o(wr_data_o),
        .wr_idx_o(wr_idx_o), .wr_last_o(wr_last_o)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic put(input int c, input logic [DW-1:0] d);
        s_ld[c]  = 1'b1;
        s_dat[c] = d;
    endtask

    task automatic occupy(input int c0, input int c1, input int n, input string tag);
        for (int c = c0; c <= c1; c++) begin
            s_ins[c] = 1'b1;
            s_itm[c] = CW'(n);
            s_tag[c] = tag;
        end
    endtask

    task automatic take(input int c, input int idx, input bit last);
        exp_t e;
        s_tok[c] = 1'b1;
        e.d = s_dat[c-2];
        e.i = CW'(idx);
        e.l = last;
        q.push_back(e);
    endtask

    initial begin
        for (int c = 0; c < NC; c++) begin
            s_tag[c] = "R8";
            s_dat[c] = '0;
            s_itm[c] = '0;
        end
        s_rst[0] = 1; s_rst[1] = 1; s_rst[2] = 1;
        // R1: idle right after reset, then instruction with empty chain
        s_tag[3] = "R1";
        occupy(4, 5, 1, "R1");
        // R2 / R5: single word, two-cycle latency
        put(10, 32'hA5A5_0001);
        occupy(10, 12, 1, "R2");
        s_tag[12] = "R5";
        take(12, 0, 1);
        // R7: four-item vector back to back
        for (int k = 0; k < 4; k++) put(20 + k, 32'h2000_0000 + k);
        occupy(20, 25, 4, "R7");
        for (int k = 0; k < 4; k++) take(22 + k, k, k == 3);
        // R7 / R3: three-item vector with gaps, chain keeps shifting
        put(30, 32'h3000_0000); put(33, 32'h3000_0001); put(34, 32'h3000_0002);
        occupy(30, 36, 3, "R7");
        s_tag[33] = "R3"; s_tag[34] = "R3";
        take(32, 0, 0); take(35, 1, 0); take(36, 2, 1);
        // R6 / R3: missing token, first word expires, later word taken
        put(40, 32'hDEAD_0040); put(43, 32'h4000_0043);
        occupy(40, 45, 1, "R6");
        s_tag[45] = "R3";
        take(45, 0, 1);
        // R1: partial vector, then reset discards a word and the index
        put(47, 32'h4700_0000);
        occupy(47, 49, 2, "R7");
        take(49, 0, 0);
        put(50, 32'h5000_0050);
        s_rst[51] = 1;
        occupy(53, 54, 1, "R1");
        put(60, 32'h6000_0060); put(61, 32'h6000_0061);
        occupy(60, 63, 2, "R1");
        take(62, 0, 0); take(63, 1, 1);
        // R7: item count zero acts as one
        put(70, 32'h7000_0070);
        occupy(70, 72, 0, "R7");
        take(72, 0, 1);

        for (int c = 0; c < NC; c++) begin
            bit arrive, exp_done, exp_stall;
            @(posedge clk);
            #1;
            rst_n       = !s_rst[c];
            ld_vld_i    = s_ld[c];
            ld_data_i   = s_dat[c];
            fin_tok_i   = s_tok[c];
            ins_vld_i   = s_ins[c];
            ins_items_i = s_itm[c];
            #3;
            arrive    = (c >= 2) && s_ld[c-2] && !s_rst[c-2] && !s_rst[c-1];
            exp_done  = s_ins[c] && arrive && s_tok[c];
            exp_stall = s_ins[c] && !exp_done;
            chk(stall_o == exp_stall, s_tag[c], $sformatf("stall c%0d", c), stall_o, exp_stall);
            chk(done_o == exp_done, s_tag[c], $sformatf("done c%0d", c), done_o, exp_done);
            if (done_o) begin
                if (q.size() == 0) begin
                    chk(0, s_tag[c], "unexpected completion", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(wr_data_o == e.d, s_tag[c], $sformatf("data c%0d", c), wr_data_o, e.d);
                    chk(wr_idx_o == e.i, s_tag[c], $sformatf("idx c%0d", c), wr_idx_o, e.i);
                    chk(wr_last_o == e.l, s_tag[c], $sformatf("last c%0d", c), wr_last_o, e.l);
                end
            end else begin
                chk(wr_last_o == 1'b0, s_tag[c], $sformatf("last idle c%0d", c), wr_last_o, 0);
            end
        end
        chk(q.size() == 0, "R5", "completions left over", q.size(), 0);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(NC * 10 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not finish actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule